// File: doc/BRIEF.md
# Flow-Controlled Serial Link Transceiver

This block is an asynchronous serial transceiver meant to carry a host-link transport between two chips on one board. Outgoing bytes are written into a 128-entry transmit queue and leave on the serial line as frames of one start bit, eight data bits (least significant first) and one stop bit, with no parity. Incoming frames are recovered by a receiver that samples the line sixteen times per bit. Each byte lands in a 128-entry receive queue together with a flag that marks a bad stop bit.

Hardware flow control runs in both directions. A new outgoing frame starts only while the remote clear-to-send input is 1. The local ready-to-receive output drops on its own once the receive queue reaches a high-water mark, so that bytes still in flight from the remote sender have room. It comes back once the queue drains below a low-water mark. The bit rate is chosen from a table of twenty standard rates, from 300 bit/s to 921.6 kbit/s, and after reset the rate is 57.6 kbit/s. The host side is a plain push/pop queue interface with level outputs and two threshold interrupts. While reset is held, the transmit line is driven low.

Top module: `hostlink_uart`

## Requirements
- R1: After a clock edge with `rst_n` low, `uart_txd` is 0, `rts` is 1, both levels are 0 and `rx_empty` is 1. Within two clock edges of `rst_n` returning high, with nothing queued, `uart_txd` is 1.
- R2: Each transmitted frame is one start bit at 0, then eight data bits least significant first, then a stop bit at 1. Every bit lasts 16 baud ticks.
- R3: One baud tick lasts D clock cycles, where D = floor((CLK_HZ + 8*rate) / (16*rate)), which is the nearest integer to CLK_HZ/(16*rate). The rate index gives rate: 0=921600, 1=460800, 2=230400, 3=153600, 4=115200, 5=76800, 6=57600, 7=38400, 8=28800, 9=19200, 10=14400, 11=9600, 12=7200, 13=4800, 14=2400, 15=1800, 16=1200, 17=900, 18=600, 19 and above=300. Reset selects index 6. A cycle with `rate_wr` at 1 loads `rate_sel`.
- R4: A new frame starts only if `cts` was 1 two clock edges before. While `cts` stays 0, queued bytes wait and `uart_txd` stays 1.
- R5: The transmit queue holds 128 bytes and sends them in order. A `tx_wr` while `tx_full` is 1 is ignored.
- R6: The receiver arms on a 1-to-0 transition of the line and confirms the start bit half a bit later. A low pulse shorter than half a bit stores nothing. Data bits are taken at their centres, least significant first.
- R7: A byte whose stop bit is sampled as 0 is still stored, and `rx_ferr` is 1 while that byte is at the head of the queue. For a good stop bit, `rx_ferr` is 0.
- R8: The receive queue holds 128 bytes and presents them in order on `rx_data`. A byte that completes while the queue is full is discarded, and `rx_overrun` pulses for one cycle. A `rx_rd` while the queue is empty has no effect.
- R9: `rx_irq` is 1 exactly when `rx_level >= rx_thresh`. `tx_irq` is 1 exactly when the free transmit space (128 - `tx_level`) is at least `tx_thresh`.
- R10: One cycle after `rx_level >= rts_hi`, `rts` is 0. It returns to 1 one cycle after `rx_level < rts_lo`. Between the two marks it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_wr | input | 1 | Load strobe for the rate index |
| rate_sel | input | 5 | Rate index to load |
| tx_wr | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit queue full |
| tx_level | output | 8 | Bytes waiting in the transmit queue |
| tx_thresh | input | 8 | Free-space threshold for `tx_irq` (1..128) |
| tx_irq | output | 1 | Transmit space interrupt |
| rx_rd | input | 1 | Pop the head of the receive queue |
| rx_data | output | 8 | Byte at the head of the receive queue |
| rx_ferr | output | 1 | Framing-error flag of the head byte |
| rx_empty | output | 1 | Receive queue empty |
| rx_level | output | 8 | Bytes held in the receive queue |
| rx_thresh | input | 7 | Fill threshold for `rx_irq` (1..127) |
| rx_irq | output | 1 | Receive fill interrupt |
| rx_overrun | output | 1 | One-cycle pulse: a byte was dropped |
| rts_hi | input | 8 | Fill level that lowers `rts` |
| rts_lo | input | 8 | Fill level below which `rts` rises again |
| uart_txd | output | 1 | Serial transmit line |
| uart_rxd | input | 1 | Serial receive line |
| cts | input | 1 | Remote side ready to receive |
| rts | output | 1 | Local side ready to receive |

## Verification
Queue levels, `tx_full`, `rx_empty` and the head byte change at the clock edge that takes the strobe. `rts` follows one edge after the level crosses a mark. A decision on `cts` needs two synchronizer edges plus up to one baud tick before the start bit appears. A received byte enters the queue half a stop bit after that stop bit begins. The bench drives inputs and samples outputs 1 ns after a rising edge. It reads queue state only after at least one further edge, and lets a whole idle bit pass after each driven frame. It decodes transmitted frames at bit centres counted from the detected start edge, and it checks bit length by counting cycles exactly.

// File: rtl/hlu_pkg.sv
// Shared types and rate arithmetic for the serial link transceiver.
// Assumes: rate indices above the table end select the slowest rate.
package hlu_pkg;

    localparam int RATE_N      = 20;
    localparam int RATE_W      = 5;
    localparam int DEFAULT_IDX = 6;

    typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} frame_st_e;

    // Bit rate for a table index.
    function automatic int unsigned rate_bps(input int idx);
        case (idx)
            0:       return 921600;
            1:       return 460800;
            2:       return 230400;
            3:       return 153600;
            4:       return 115200;
            5:       return 76800;
            6:       return 57600;
            7:       return 38400;
            8:       return 28800;
            9:       return 19200;
            10:      return 14400;
            11:      return 9600;
            12:      return 7200;
            13:      return 4800;
            14:      return 2400;
            15:      return 1800;
            16:      return 1200;
            17:      return 900;
            18:      return 600;
            default: return 300;
        endcase
    endfunction

    // Clock cycles per sixteenth of a bit, rounded to nearest, never below 1.
    function automatic int unsigned div16(input longint clk_hz, input int unsigned rate);
        longint q;
        q = (clk_hz + longint'(rate) * 8) / (longint'(rate) * 16);
        if (q < 1) q = 1;
        return int'(q);
    endfunction

endpackage

// File: rtl/hlu_baudgen.sv
// Oversampling tick generator: one-cycle pulse every D cycles, D from the
// rate table. Assumes CLK_HZ is the real clock frequency. A rate change
// takes effect at once; a counter past the new limit wraps on the next cycle.
module hlu_baudgen #(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [hlu_pkg::RATE_W-1:0] rate_idx,
    output logic                      tick
);
    import hlu_pkg::*;

    localparam int DIV_W = $clog2(div16(CLK_HZ, 300) + 1);

    logic [DIV_W-1:0] div_tab [RATE_N];
    logic [DIV_W-1:0] div_sel;
    logic [DIV_W-1:0] cnt;

    // One constant divisor per table entry.
    for (genvar g = 0; g < RATE_N; g++) begin : g_div
        assign div_tab[g] = DIV_W'(div16(CLK_HZ, rate_bps(g)));
    end

    // Pick the active divisor, clamping out-of-range indices.
    always_comb begin
        if (rate_idx < RATE_W'(RATE_N)) div_sel = div_tab[rate_idx];
        else                            div_sel = div_tab[RATE_N-1];
    end

    assign tick = (cnt >= div_sel - 1'b1);

    // Free-running divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hlu_fifo.sv
// Show-ahead synchronous queue. Assumes DEPTH is a power of two.
// A push when full and a pop when empty are dropped.
module hlu_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    // Storage write, no reset needed.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    // Pointer and fill bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/hlu_tx.sv
// Frame serializer: 8N1, LSB first, 16 ticks per bit. Starts a frame only on
// a tick with a byte queued and the synchronized clear-to-send high.
// Line is low in reset and returns high on the first edge after release.
module hlu_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cts_ok,
    input  logic       q_empty,
    input  logic [7:0] q_data,
    output logic       q_pop,
    output logic       txd
);
    import hlu_pkg::*;

    frame_st_e  st;
    logic [3:0] cnt;
    logic [2:0] bitn;
    logic [7:0] sh;

    assign q_pop = tick && (st == ST_IDLE) && !q_empty && cts_ok;

    // Frame sequencing and line drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            bitn <= '0;
            sh   <= '0;
            txd  <= 1'b0;
        end else begin
            if (st == ST_IDLE) txd <= 1'b1;
            if (tick) begin
                case (st)
                    ST_IDLE: begin
                        if (q_pop) begin
                            sh  <= q_data;
                            txd <= 1'b0;
                            cnt <= '0;
                            st  <= ST_START;
                        end
                    end
                    ST_START: begin
                        if (cnt == 4'd15) begin
                            cnt  <= '0;
                            bitn <= '0;
                            txd  <= sh[0];
                            st   <= ST_DATA;
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_DATA: begin
                        if (cnt == 4'd15) begin
                            cnt <= '0;
                            if (bitn == 3'd7) begin
                                txd <= 1'b1;
                                st  <= ST_STOP;
                            end else begin
                                bitn <= bitn + 1'b1;
                                sh   <= {1'b0, sh[7:1]};
                                txd  <= sh[1];
                            end
                        end else cnt <= cnt + 1'b1;
                    end
                    default: begin
                        if (cnt == 4'd15) begin
                            cnt <= '0;
                            st  <= ST_IDLE;
                        end else cnt <= cnt + 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/hlu_rx.sv
// Frame deserializer with 16x oversampling. Arms on a sampled 1-to-0 edge,
// confirms the start bit 8 ticks later, samples data and stop at bit centres.
// Assumes rxd is already synchronized to clk.
module hlu_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic       q_full,
    output logic       q_push,
    output logic [8:0] q_wdata,
    output logic       overrun
);
    import hlu_pkg::*;

    frame_st_e  st;
    logic [3:0] cnt;
    logic [2:0] bitn;
    logic [7:0] sh;
    logic       prev;
    logic       stop_now;

    assign stop_now = tick && (st == ST_STOP) && (cnt == 4'd15);
    assign q_push   = stop_now && !q_full;
    assign overrun  = stop_now && q_full;
    assign q_wdata  = {~rxd, sh};

    // Previous tick sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)    prev <= 1'b1;
        else if (tick) prev <= rxd;
    end

    // Frame recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            bitn <= '0;
            sh   <= '0;
        end else if (tick) begin
            case (st)
                ST_IDLE: begin
                    if (prev && !rxd) begin
                        cnt <= '0;
                        st  <= ST_START;
                    end
                end
                ST_START: begin
                    if (cnt == 4'd7) begin
                        cnt  <= '0;
                        bitn <= '0;
                        st   <= rxd ? ST_IDLE : ST_DATA;
                    end else cnt <= cnt + 1'b1;
                end
                ST_DATA: begin
                    if (cnt == 4'd15) begin
                        cnt <= '0;
                        sh  <= {rxd, sh[7:1]};
                        if (bitn == 3'd7) st <= ST_STOP;
                        else              bitn <= bitn + 1'b1;
                    end else cnt <= cnt + 1'b1;
                end
                default: begin
                    if (cnt == 4'd15) begin
                        cnt <= '0;
                        st  <= ST_IDLE;
                    end else cnt <= cnt + 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/hostlink_uart.sv
// Flow-controlled 8N1 serial transceiver with deep queues, threshold
// interrupts and automatic ready-to-receive control.
// Assumes: CLK_HZ matches clk; DEPTH is a power of two; cts and uart_rxd
// are asynchronous and pass two-flop synchronizers here.
module hostlink_uart #(
    parameter int CLK_HZ = 100_000_000,
    parameter int DEPTH  = 128,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rate_wr,
    input  logic [hlu_pkg::RATE_W-1:0] rate_sel,
    input  logic                      tx_wr,
    input  logic [7:0]                tx_data,
    output logic                      tx_full,
    output logic [LW-1:0]             tx_level,
    input  logic [LW-1:0]             tx_thresh,
    output logic                      tx_irq,
    input  logic                      rx_rd,
    output logic [7:0]                rx_data,
    output logic                      rx_ferr,
    output logic                      rx_empty,
    output logic [LW-1:0]             rx_level,
    input  logic [LW-2:0]             rx_thresh,
    output logic                      rx_irq,
    output logic                      rx_overrun,
    input  logic [LW-1:0]             rts_hi,
    input  logic [LW-1:0]             rts_lo,
    output logic                      uart_txd,
    input  logic                      uart_rxd,
    input  logic                      cts,
    output logic                      rts
);
    import hlu_pkg::*;

    logic [RATE_W-1:0] rate_q;
    logic              tick;
    logic              cts_s1, cts_sync;
    logic              rxd_s1, rxd_sync;
    logic              tx_empty, tx_pop;
    logic [7:0]        txq_data;
    logic              rx_push, rx_full;
    logic [8:0]        rx_wdata, rx_head;

    // Rate index register, reset to the default rate.
    always_ff @(posedge clk) begin
        if (!rst_n)       rate_q <= RATE_W'(DEFAULT_IDX);
        else if (rate_wr) rate_q <= rate_sel;
    end

    // Two-flop synchronizers for the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cts_s1   <= 1'b0;
            cts_sync <= 1'b0;
            rxd_s1   <= 1'b1;
            rxd_sync <= 1'b1;
        end else begin
            cts_s1   <= cts;
            cts_sync <= cts_s1;
            rxd_s1   <= uart_rxd;
            rxd_sync <= rxd_s1;
        end
    end

    hlu_baudgen #(.CLK_HZ(CLK_HZ)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_idx (rate_q),
        .tick     (tick)
    );

    hlu_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_wr),
        .wdata (tx_data),
        .pop   (tx_pop),
        .rdata (txq_data),
        .level (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    hlu_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cts_ok  (cts_sync),
        .q_empty (tx_empty),
        .q_data  (txq_data),
        .q_pop   (tx_pop),
        .txd     (uart_txd)
    );

    hlu_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .rxd     (rxd_sync),
        .q_full  (rx_full),
        .q_push  (rx_push),
        .q_wdata (rx_wdata),
        .overrun (rx_overrun)
    );

    hlu_fifo #(.W(9), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_wdata),
        .pop   (rx_rd),
        .rdata (rx_head),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign rx_data = rx_head[7:0];
    assign rx_ferr = rx_head[8];
    assign rx_irq  = (rx_level >= {1'b0, rx_thresh});
    assign tx_irq  = ((LW'(DEPTH) - tx_level) >= tx_thresh);

    // Ready-to-receive with high/low water hysteresis.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rts <= 1'b1;
        else if (rx_level >= rts_hi) rts <= 1'b0;
        else if (rx_level < rts_lo)  rts <= 1'b1;
    end
endmodule

// File: rtl/hostlink_uart_chk.sv
// Property checker for hostlink_uart, attached by bind.
module hostlink_uart_chk #(
    parameter int DEPTH = 128,
    parameter int LW    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          uart_txd,
    input logic          cts,
    input logic          tx_pop,
    input logic          tx_wr,
    input logic          tx_full,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic          rx_overrun,
    input logic          rts,
    input logic [LW-1:0] rts_hi,
    input logic [LW-1:0] rts_lo
);
    p_txd_low_in_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !uart_txd);

    p_start_after_cts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> $past(cts, 2));

    p_full_push_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && tx_wr && !tx_pop) |=> (tx_level == $past(tx_level)));

    p_rx_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= LW'(DEPTH));

    p_overrun_only_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> (rx_level == LW'(DEPTH)));

    p_rts_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rts) |-> ($past(rx_level) >= $past(rts_hi)));

    p_rts_raise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts) |-> ($past(rx_level) < $past(rts_lo)));
endmodule

bind hostlink_uart hostlink_uart_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .uart_txd   (uart_txd),
    .cts        (cts),
    .tx_pop     (tx_pop),
    .tx_wr      (tx_wr),
    .tx_full    (tx_full),
    .tx_level   (tx_level),
    .rx_level   (rx_level),
    .rx_overrun (rx_overrun),
    .rts        (rts),
    .rts_hi     (rts_hi),
    .rts_lo     (rts_lo)
);

// File: tb/sim_hostlink_uart.sv
// Directed bench. The block is told its clock is 29.4912 MHz so that the
// divisors come out small (2 at 921.6k, 32 at 57.6k); the 10 ns period only
// sets simulation time.
module sim_hostlink_uart;
    localparam int CLK_HZ = 29_491_200;
    localparam int DEPTH  = 128;
    localparam int LW     = 8;
    localparam int FAST   = 16 * ((CLK_HZ + 921600 * 8) / (921600 * 16)); // cycles per bit, index 0
    localparam int SLOW   = 16 * ((CLK_HZ + 57600 * 8) / (57600 * 16));   // cycles per bit, index 6

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rate_wr = 1'b0;
    logic [4:0]    rate_sel = '0;
    logic          tx_wr = 1'b0;
    logic [7:0]    tx_data = '0;
    logic          tx_full;
    logic [LW-1:0] tx_level;
    logic [LW-1:0] tx_thresh = 8'd1;
    logic          tx_irq;
    logic          rx_rd = 1'b0;
    logic [7:0]    rx_data;
    logic          rx_ferr, rx_empty;
    logic [LW-1:0] rx_level;
    logic [LW-2:0] rx_thresh = 7'd1;
    logic          rx_irq, rx_overrun;
    logic [LW-1:0] rts_hi = 8'd120;
    logic [LW-1:0] rts_lo = 8'd100;
    logic          uart_txd;
    logic          uart_rxd = 1'b1;
    logic          cts = 1'b1;
    logic          rts;

    int  n_chk = 0;
    int  n_err = 0;
    int  ovr_cnt = 0;
    bit  done = 0;

    always #5 clk = ~clk;

    hostlink_uart #(.CLK_HZ(CLK_HZ), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_sel(rate_sel),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full), .tx_level(tx_level),
        .tx_thresh(tx_thresh), .tx_irq(tx_irq), .rx_rd(rx_rd), .rx_data(rx_data),
        .rx_ferr(rx_ferr), .rx_empty(rx_empty), .rx_level(rx_level),
        .rx_thresh(rx_thresh), .rx_irq(rx_irq), .rx_overrun(rx_overrun),
        .rts_hi(rts_hi), .rts_lo(rts_lo), .uart_txd(uart_txd), .uart_rxd(uart_rxd),
        .cts(cts), .rts(rts)
    );

    // Count dropped-byte pulses.
    always @(posedge clk) if (rst_n && rx_overrun) ovr_cnt++;

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_wr = 1'b1; tx_data = b;
        cyc(1);
        tx_wr = 1'b0;
    endtask

    task automatic pop_rx();
        rx_rd = 1'b1;
        cyc(1);
        rx_rd = 1'b0;
        cyc(1);
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop_bit, input int bitc);
        uart_rxd = 1'b0;
        cyc(bitc);
        for (int i = 0; i < 8; i++) begin
            uart_rxd = b[i];
            cyc(bitc);
        end
        uart_rxd = stop_bit;
        cyc(bitc);
        uart_rxd = 1'b1;
        cyc(bitc);
    endtask

    task automatic get_tx(input int bitc, input int tmo, output logic [7:0] b,
                          output logic stop_ok, output logic found);
        found = 1'b0; b = '0; stop_ok = 1'b0;
        for (int n = 0; n < tmo; n++) begin
            if (!uart_txd) begin found = 1'b1; break; end
            cyc(1);
        end
        if (!found) return;
        cyc(bitc / 2);
        for (int i = 0; i < 8; i++) begin
            cyc(bitc);
            b[i] = uart_txd;
        end
        cyc(bitc);
        stop_ok = uart_txd;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cyc(5);
        chk("R1 txd low in reset", uart_txd, 0);
        chk("R1 rts in reset", rts, 1);
        chk("R1 tx_level in reset", tx_level, 0);
        chk("R1 rx_level in reset", rx_level, 0);
        chk("R1 rx_empty in reset", rx_empty, 1);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 txd idle after release", uart_txd, 1);
    endtask

    task automatic t_default_rate();
        int lowc = 0;
        logic seen = 1'b0;
        push_tx(8'h00);
        for (int n = 0; n < 2000; n++) begin
            if (!uart_txd) begin seen = 1'b1; break; end
            cyc(1);
        end
        chk("R3 default-rate start seen", seen, 1);
        while (!uart_txd && lowc < 20000) begin
            lowc++;
            cyc(1);
        end
        chk("R3 default 57.6k: nine low bits in cycles", lowc, 9 * SLOW);
        cyc(2 * SLOW);
        rate_sel = 5'd0; rate_wr = 1'b1;
        cyc(1);
        rate_wr = 1'b0;
        cyc(2);
    endtask

    task automatic t_tx_frames();
        logic [7:0] b; logic s, f;
        push_tx(8'hA5);
        push_tx(8'h3C);
        get_tx(FAST, 200, b, s, f);
        chk("R2 first frame byte", b, 8'hA5);
        chk("R2 first frame stop", s, 1);
        get_tx(FAST, 200, b, s, f);
        chk("R2 second frame byte", b, 8'h3C);
        chk("R2 second frame stop", s, 1);
    endtask

    task automatic t_cts_gate();
        logic [7:0] b; logic s, f;
        int lows = 0;
        cts = 1'b0;
        cyc(5);
        push_tx(8'h5A);
        for (int n = 0; n < 30 * FAST; n++) begin
            if (!uart_txd) lows++;
            cyc(1);
        end
        chk("R4 line held idle while cts low", lows, 0);
        chk("R4 byte still queued", tx_level, 1);
        cts = 1'b1;
        get_tx(FAST, 200, b, s, f);
        chk("R4 byte sent after cts high", b, 8'h5A);
    endtask

    task automatic t_tx_full();
        logic [7:0] b; logic s, f;
        int bad = 0;
        cts = 1'b0;
        cyc(5);
        for (int i = 0; i <= DEPTH; i++) push_tx(8'(i));
        cyc(1);
        chk("R5 tx_level at capacity", tx_level, DEPTH);
        chk("R5 tx_full", tx_full, 1);
        tx_thresh = 8'd1;
        cyc(1);
        chk("R9 tx_irq off with no space", tx_irq, 0);
        cts = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            get_tx(FAST, 200, b, s, f);
            if (!f || b != 8'(i) || !s) bad++;
        end
        chk("R5 128 bytes sent in order", bad, 0);
        get_tx(FAST, 30 * FAST, b, s, f);
        chk("R5 extra push was dropped", f, 0);
        chk("R5 queue drained", tx_level, 0);
    endtask

    task automatic t_tx_irq();
        tx_thresh = 8'd128;
        cyc(1);
        chk("R9 tx_irq with 128 free", tx_irq, 1);
        cts = 1'b0;
        cyc(5);
        push_tx(8'h11);
        cyc(1);
        chk("R9 tx_irq off with 127 free, thresh 128", tx_irq, 0);
        tx_thresh = 8'd127;
        cyc(1);
        chk("R9 tx_irq with 127 free, thresh 127", tx_irq, 1);
        cts = 1'b1;
        cyc(12 * FAST);
        tx_thresh = 8'd1;
    endtask

    task automatic t_rx_frames();
        rx_thresh = 7'd2;
        send_rx(8'h81, 1'b1, FAST);
        chk("R6 one byte stored", rx_level, 1);
        chk("R9 rx_irq below threshold", rx_irq, 0);
        send_rx(8'h3C, 1'b1, FAST);
        chk("R9 rx_irq at threshold", rx_irq, 1);
        chk("R6 first received byte", rx_data, 8'h81);
        chk("R7 good stop flag clear", rx_ferr, 0);
        pop_rx();
        chk("R6 second received byte", rx_data, 8'h3C);
        pop_rx();
        chk("R8 empty after pops", rx_empty, 1);
        pop_rx();
        chk("R8 pop on empty has no effect", rx_level, 0);
        rx_thresh = 7'd1;
    endtask

    task automatic t_ferr_glitch();
        send_rx(8'hC3, 1'b0, FAST);
        chk("R7 bad-stop byte stored", rx_data, 8'hC3);
        chk("R7 framing flag set", rx_ferr, 1);
        pop_rx();
        uart_rxd = 1'b0;
        cyc(FAST / 2 - 10);
        uart_rxd = 1'b1;
        cyc(15 * FAST);
        chk("R6 short low pulse rejected", rx_level, 0);
    endtask

    task automatic t_rts();
        rts_hi = 8'd4; rts_lo = 8'd2;
        cyc(2);
        for (int i = 0; i < 3; i++) send_rx(8'(8'h40 + i), 1'b1, FAST);
        chk("R10 rts high below mark", rts, 1);
        send_rx(8'h43, 1'b1, FAST);
        chk("R10 rts low at high mark", rts, 0);
        pop_rx();
        pop_rx();
        chk("R10 rts held between marks", rts, 0);
        pop_rx();
        cyc(1);
        chk("R10 rts back below low mark", rts, 1);
        pop_rx();
        rts_hi = 8'd120; rts_lo = 8'd100;
    endtask

    task automatic t_overrun();
        int bad = 0;
        ovr_cnt = 0;
        for (int i = 0; i <= DEPTH; i++) send_rx(8'(i), 1'b1, FAST);
        chk("R8 rx_level at capacity", rx_level, DEPTH);
        chk("R8 one overrun pulse", ovr_cnt, 1);
        for (int i = 0; i < DEPTH; i++) begin
            if (rx_data != 8'(i)) bad++;
            pop_rx();
        end
        chk("R8 stored bytes in order, last dropped", bad, 0);
        chk("R8 empty after draining", rx_empty, 1);
    endtask

    initial begin
        t_reset();
        t_default_rate();
        t_tx_frames();
        t_cts_gate();
        t_tx_irq();
        t_tx_full();
        t_rx_frames();
        t_ferr_glitch();
        t_rts();
        t_overrun();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule